// File: doc/BRIEF.md
# Two-Slot Reserving Read Scheduler

This block sits on the processor side of a memory channel whose data bus is cut into fixed time slots. One slot is the time the bus needs to move one cache line. The block never sequences device commands. For each accepted read it books two future data-bus slots at once: a primary slot and a later backup slot. Both slots lie at least one memory latency beyond the current slot. The memory side receives only the address and the slot numbers, and it returns the data in one of the two booked slots. The processor side alone decides who owns every slot.

Reservations live in a circular table with one entry per slot. The entry is indexed by the running slot count modulo the table size. Each entry stores a state (free, primary or backup), the tag of its owner, and for a primary the index of its backup partner. The latency is given in slot units by the memory side and is captured while reset is held. When memory reports that it missed a primary slot, the request finishes in its backup slot. Otherwise the backup is returned to the free pool when the primary slot ends. Each completion produces a one-cycle return pulse that carries the owner's tag.

A two-state controller gates acceptance. ST_WARM holds for the first cycle after reset with ready low, and then moves unconditionally to ST_RUN. ST_RUN has no exit other than reset. In ST_RUN, ready follows the availability of two free slots.

Top module: `slot_sched`

## Requirements
- R1: While reset is asserted and at its release, no slot is reserved, `slot_now` is 0, and `iss_valid` and `ret_valid` are low. `req_ready` is low in the first cycle after release (ST_WARM) and high in the next cycle (ST_RUN, empty table).
- R2: `slot_now` advances by one every 4 clock cycles and wraps from 63 to 0.
- R3: The primary slot is the first free slot at an offset of at least L from the slot current at acceptance, where L is the latency captured during reset. Changing `mem_lat` after reset has no effect.
- R4: The backup slot is the first free slot at an offset strictly greater than that of the primary slot.
- R5: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. In the next cycle `iss_valid` is high for one cycle with the request's address and tag and both slot numbers, and `slot_busy` shows both slots reserved.
- R6: When a primary slot ends and no failure was reported during it, `ret_valid` pulses in the first cycle of the following slot with the owner's tag. Both that slot and its backup are free in the same cycle.
- R7: When `resp_fail` is high in any cycle of a primary slot, no return follows that slot. The backup stays reserved, and the return comes in the first cycle after the backup slot with the same tag.
- R8: `resp_fail` has no effect while the current slot is free or is a backup slot.
- R9: `req_ready` is low exactly when fewer than two free slots exist at offsets L through 63 from the current slot (or in ST_WARM).
- R10: A captured latency of 0 is treated as 1. Values above 62 are limited to 62.
- R11: A slot released on the same edge as an acceptance is treated as still reserved by that acceptance, so neither new slot was reserved before the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; latency is captured while low |
| mem_lat | input | 5 | Memory latency in slot units, from the memory side |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 16 | Read address |
| req_tag | input | 4 | Request tag |
| iss_valid | output | 1 | Issue toward memory valid (one cycle) |
| iss_addr | output | 16 | Issued address |
| iss_tag | output | 4 | Issued tag |
| iss_pslot | output | 6 | Primary slot number |
| iss_bslot | output | 6 | Backup slot number |
| resp_fail | input | 1 | Memory missed the current primary slot |
| slot_now | output | 6 | Current slot index |
| slot_busy | output | 64 | Per-slot reservation state (1 = reserved) |
| ret_valid | output | 1 | Data returned for a completed request |
| ret_tag | output | 4 | Tag of the completed request |

## Verification
An acceptance is seen at the first falling edge after the accepting rising edge, because the issue fields and the table update come through one register stage. The bench reads `slot_now` at the falling edge just before acceptance and computes both expected slot numbers from that value. A return appears in the first cycle of the slot after the completing slot. The bench therefore polls at falling edges and checks that `slot_now` already equals the completing slot plus one when `ret_valid` is first seen. The failure pin is driven at falling edges for every cycle of the slot in question. Cases where nothing should happen (a failure in a free or backup slot, no second return) are checked over a full window of several slots.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    typedef enum logic {
        ST_WARM,
        ST_RUN
    } run_t;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_PRIM = 2'd1,
        SL_BACK = 2'd2
    } slot_st_t;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYC = 4,
    parameter int OFF_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OFF_W-1:0] cur,
    output logic             slot_end
);
    localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);

    logic [PH_W-1:0] phase;

    assign slot_end = (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            cur   <= '0;
        end else if (slot_end) begin
            phase <= '0;
            cur   <= cur + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int SLOTS = 64,
    parameter int OFF_W = 6
) (
    input  logic [SLOTS-1:0] free_rot,
    input  logic [OFF_W:0]   start,
    output logic             found,
    output logic [OFF_W-1:0] off
);
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (free_rot[i] && (i >= int'(start))) begin
                found = 1'b1;
                off   = OFF_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int SLOTS    = 64,
    parameter int SLOT_CYC = 4,
    parameter int ADDR_W   = 16,
    parameter int TAG_W    = 4,
    parameter int LAT_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LAT_W-1:0]         mem_lat,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [TAG_W-1:0]         req_tag,
    output logic                     iss_valid,
    output logic [ADDR_W-1:0]        iss_addr,
    output logic [TAG_W-1:0]         iss_tag,
    output logic [$clog2(SLOTS)-1:0] iss_pslot,
    output logic [$clog2(SLOTS)-1:0] iss_bslot,
    input  logic                     resp_fail,
    output logic [$clog2(SLOTS)-1:0] slot_now,
    output logic [SLOTS-1:0]         slot_busy,
    output logic                     ret_valid,
    output logic [TAG_W-1:0]         ret_tag
);
    localparam int OFF_W   = $clog2(SLOTS);
    localparam int LAT_MAX = SLOTS - 2;

    run_t             st_q, st_d;
    slot_st_t         sl_st  [SLOTS];
    logic [TAG_W-1:0] sl_tag [SLOTS];
    logic [OFF_W-1:0] sl_part[SLOTS];

    logic [OFF_W-1:0] cur, lat_q, lat_in, p_off, b_off, p_idx, b_idx;
    logic             slot_end, p_found, b_found, accept;
    logic             fail_seen, cur_prim, fail_now, done_now;
    logic [SLOTS-1:0] free_rot;

    // latency clamp: 0 -> 1, above window limit -> SLOTS-2 (R10)
    always_comb begin
        if (int'(mem_lat) < 1)            lat_in = OFF_W'(1);
        else if (int'(mem_lat) > LAT_MAX) lat_in = OFF_W'(LAT_MAX);
        else                              lat_in = OFF_W'(mem_lat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= lat_in;
    end

    slot_timer #(.SLOT_CYC(SLOT_CYC), .OFF_W(OFF_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur),
        .slot_end (slot_end)
    );

    // table viewed from the current slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_rot
        assign free_rot[g]  = (sl_st[cur + OFF_W'(g)] == SL_FREE);
        assign slot_busy[g] = (sl_st[g] != SL_FREE);
    end

    slot_pick #(.SLOTS(SLOTS), .OFF_W(OFF_W)) pick_p_i (
        .free_rot (free_rot),
        .start    ({1'b0, lat_q}),
        .found    (p_found),
        .off      (p_off)
    );

    slot_pick #(.SLOTS(SLOTS), .OFF_W(OFF_W)) pick_b_i (
        .free_rot (free_rot),
        .start    ({1'b0, p_off} + 1'b1),
        .found    (b_found),
        .off      (b_off)
    );

    assign p_idx = cur + p_off;
    assign b_idx = cur + b_off;

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_WARM;
        else        st_q <= st_d;
    end

    // controller: next state and outputs
    always_comb begin
        st_d      = st_q;
        req_ready = 1'b0;
        unique case (st_q)
            ST_WARM: st_d = ST_RUN;
            ST_RUN:  req_ready = p_found && b_found;
            default: st_d = ST_WARM;
        endcase
    end

    assign accept   = req_valid && req_ready;
    assign cur_prim = (sl_st[cur] == SL_PRIM);
    assign fail_now = fail_seen || (resp_fail && cur_prim);
    assign done_now = (cur_prim && !fail_now) || (sl_st[cur] == SL_BACK);

    always_ff @(posedge clk) begin
        if (!rst_n)        fail_seen <= 1'b0;
        else if (slot_end) fail_seen <= 1'b0;
        else if (fail_now) fail_seen <= 1'b1;
    end

    // reservation table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                sl_st[i]   <= SL_FREE;
                sl_tag[i]  <= '0;
                sl_part[i] <= '0;
            end
        end else begin
            if (slot_end) begin
                sl_st[cur] <= SL_FREE;
                if (cur_prim && !fail_now) sl_st[sl_part[cur]] <= SL_FREE;
            end
            if (accept) begin
                sl_st[p_idx]   <= SL_PRIM;
                sl_tag[p_idx]  <= req_tag;
                sl_part[p_idx] <= b_idx;
                sl_st[b_idx]   <= SL_BACK;
                sl_tag[b_idx]  <= req_tag;
            end
        end
    end

    // issue and return registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_addr  <= '0;
            iss_tag   <= '0;
            iss_pslot <= '0;
            iss_bslot <= '0;
            ret_valid <= 1'b0;
            ret_tag   <= '0;
        end else begin
            iss_valid <= accept;
            if (accept) begin
                iss_addr  <= req_addr;
                iss_tag   <= req_tag;
                iss_pslot <= p_idx;
                iss_bslot <= b_idx;
            end
            ret_valid <= slot_end && done_now;
            if (slot_end && done_now) ret_tag <= sl_tag[cur];
        end
    end

    assign slot_now = cur;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int SLOTS = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     iss_valid,
    input logic [$clog2(SLOTS)-1:0] iss_pslot,
    input logic [$clog2(SLOTS)-1:0] iss_bslot,
    input logic [$clog2(SLOTS)-1:0] slot_now,
    input logic [SLOTS-1:0]         slot_busy,
    input logic                     ret_valid,
    input logic [$clog2(SLOTS)-1:0] lat_q
);
    localparam int OFF_W = $clog2(SLOTS);

    logic [SLOTS-1:0] prev_busy;
    logic [OFF_W-1:0] prev_now, p_dist, b_dist;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_busy <= '0;
            prev_now  <= '0;
        end else begin
            prev_busy <= slot_busy;
            prev_now  <= slot_now;
        end
    end

    assign p_dist = iss_pslot - prev_now;
    assign b_dist = iss_bslot - prev_now;

    assert_issue_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> iss_valid);

    assert_busy_on_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (slot_busy[iss_pslot] && slot_busy[iss_bslot]));

    assert_pick_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (!prev_busy[iss_pslot] && !prev_busy[iss_bslot]));

    assert_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (p_dist >= lat_q));

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (b_dist > p_dist));

    assert_ret_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !$stable(slot_now));
endmodule

bind slot_sched slot_sched_chk #(.SLOTS(SLOTS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .iss_valid (iss_valid),
    .iss_pslot (iss_pslot),
    .iss_bslot (iss_bslot),
    .slot_now  (slot_now),
    .slot_busy (slot_busy),
    .ret_valid (ret_valid),
    .lat_q     (lat_q)
);

// File: tb/slot_sched_tb_top.sv
module slot_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mem_lat = 5'd5;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic        iss_valid;
    logic [15:0] iss_addr;
    logic [3:0]  iss_tag;
    logic [5:0]  iss_pslot, iss_bslot, slot_now;
    logic        resp_fail = 1'b0;
    logic [63:0] slot_busy;
    logic        ret_valid;
    logic [3:0]  ret_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    slot_sched dut_i (
        .clk(clk), .rst_n(rst_n), .mem_lat(mem_lat),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tag(req_tag),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_tag(iss_tag),
        .iss_pslot(iss_pslot), .iss_bslot(iss_bslot),
        .resp_fail(resp_fail), .slot_now(slot_now), .slot_busy(slot_busy),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] lat);
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; resp_fail = 1'b0; mem_lat = lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives one request, returns slots seen at issue and slot_now before accept
    task automatic issue(input logic [15:0] a, input logic [3:0] t,
                         output logic [5:0] now, output logic [5:0] ps, output logic [5:0] bs);
        req_valid = 1'b1; req_addr = a; req_tag = t;
        while (!req_ready) @(negedge clk);
        now = slot_now;
        @(negedge clk);
        req_valid = 1'b0;
        ps = iss_pslot; bs = iss_bslot;
        check(iss_valid && iss_addr == a && iss_tag == t, "R5 issue fields",
              {iss_valid, iss_addr, iss_tag}, {1'b1, a, t});
        check(slot_busy[ps] && slot_busy[bs], "R5 busy after issue", slot_busy, 64'h0);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; mem_lat = 5'd5;
        repeat (2) @(negedge clk);
        check(slot_busy == 0 && slot_now == 0 && !iss_valid && !ret_valid, "R1 in reset",
              {slot_busy[15:0], slot_now, iss_valid, ret_valid}, 0);
        rst_n = 1'b1;
        check(!req_ready, "R1 ready low in warm", req_ready, 0);
        @(negedge clk);
        check(req_ready, "R1 ready high in run", req_ready, 1);
    endtask

    task automatic t_timer;
        do_reset(5'd5);
        repeat (4) @(negedge clk);
        check(slot_now == 6'd1, "R2 advance after 4", slot_now, 1);
        repeat (4 * 62) @(negedge clk);
        check(slot_now == 6'd63, "R2 slot 63", slot_now, 63);
        repeat (4) @(negedge clk);
        check(slot_now == 6'd0, "R2 wrap", slot_now, 0);
    endtask

    task automatic t_pick;
        logic [5:0] n1, p1, b1, n2, p2, b2;
        do_reset(5'd5);
        mem_lat = 5'd9;   // post-reset change must be ignored (R3)
        issue(16'h1234, 4'h1, n1, p1, b1);
        check(p1 == 6'(n1 + 5), "R3 primary at latency", p1, 6'(n1 + 5));
        check(b1 == 6'(n1 + 6), "R4 backup next free", b1, 6'(n1 + 6));
        issue(16'h5678, 4'h2, n2, p2, b2);
        check(p2 == 6'(n1 + 7), "R3 primary skips reserved", p2, 6'(n1 + 7));
        check(b2 == 6'(n1 + 8), "R4 backup after primary", b2, 6'(n1 + 8));
    endtask

    task automatic t_lat_zero;
        logic [5:0] n, p, b;
        do_reset(5'd0);
        issue(16'h0042, 4'h7, n, p, b);
        check(p == 6'(n + 1), "R10 zero latency as one", p, 6'(n + 1));
    endtask

    task automatic t_success;
        logic [5:0] n, p, b;
        int rets = 0;
        do_reset(5'd5);
        issue(16'h0abc, 4'h3, n, p, b);
        for (int i = 0; i < 80 && !ret_valid; i++) @(negedge clk);
        check(ret_valid && ret_tag == 4'h3, "R6 return tag", {ret_valid, ret_tag}, {1'b1, 4'h3});
        check(slot_now == 6'(p + 1), "R6 return after primary", slot_now, 6'(p + 1));
        check(!slot_busy[p] && !slot_busy[b], "R6 backup released", slot_busy, 0);
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (ret_valid) rets++;
            @(negedge clk);
        end
        check(rets == 0, "R6 no second return", rets, 0);
    endtask

    task automatic t_fail;
        logic [5:0] n, p, b, at;
        int rets = 0;
        logic [3:0] tg = 4'h0;
        do_reset(5'd5);
        issue(16'h0def, 4'h9, n, p, b);
        at = 6'h0;
        for (int i = 0; i < 60; i++) begin
            resp_fail = (slot_now == p) || (slot_now == b);
            if (ret_valid) begin rets++; at = slot_now; tg = ret_tag; end
            if (slot_now == 6'(p + 1) && i > 0 && !slot_busy[p] && rets == 0)
                check(slot_busy[b], "R7 backup kept", slot_busy, 0);
            @(negedge clk);
        end
        resp_fail = 1'b0;
        check(rets == 1, "R7 exactly one return", rets, 1);
        check(at == 6'(b + 1) && tg == 4'h9, "R7 return after backup R8", {at, tg}, {6'(b + 1), 4'h9});
    endtask

    task automatic t_ignore;
        int rets = 0;
        do_reset(5'd5);
        resp_fail = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (ret_valid) rets++;
            @(negedge clk);
        end
        resp_fail = 1'b0;
        check(rets == 0 && slot_busy == 0, "R8 fail on free slot ignored", {rets[7:0], slot_busy[7:0]}, 0);
    endtask

    task automatic t_full;
        int lows = 0, bad = 0, fr;
        do_reset(5'd31);
        req_valid = 1'b1; req_addr = 16'h0100; req_tag = 4'hc;
        for (int i = 0; i < 40; i++) begin
            fr = 0;
            for (int k = 31; k < 64; k++) if (!slot_busy[6'(slot_now + k)]) fr++;
            if (i > 0 && (req_ready != (fr >= 2))) bad++;
            if (i > 0 && !req_ready) lows++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(lows > 0, "R9 ready drops when full", lows, 1);
        check(bad == 0, "R9 ready matches free count", bad, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timer();
        t_pick();
        t_lat_zero();
        t_success();
        t_fail();
        t_ignore();
        t_full();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule